// File: doc/BRIEF.md
# Reset Vector and Configuration Unit

This block sits between the reset sources of a small 8-bit microcontroller and its CPU core. Three reset requests arrive: power-on or external pin, clock-monitor failure, and watchdog timeout. A mode input selects normal or special operation. While any effective request is high, the block holds the system in reset. It records the highest-priority cause and samples the mode. It also forces the configuration state to its start values.

When reset is released, the block reads the two-byte restart vector for that cause and mode from program memory. It takes three cycles to do so and then hands the assembled start address to the CPU. Until that hand-off it tells the CPU to keep the X, I and S condition-code bits set. A small register port exposes three registers. The first is a configuration register with a watchdog-disable bit whose write rules depend on the mode. The second holds the recorded reset cause. The third is the memory-map init register. All the pins are plain level or pulse signals. There is no streaming interface and so no back-pressure: `start_valid` is a one-cycle announcement that cannot be stalled, and `fetch_data` must be valid in the same cycle as `fetch_addr`.

Top module: `rstvec_unit`

## Requirements
- R1: When several requests are high together, the recorded cause follows the order power-on/pin, then clock-monitor, then watchdog. Reading register address 1 returns the cause code in bits 1:0 (3 power-on/pin, 2 clock-monitor, 1 watchdog) until the next reset.
- R2: In normal mode (`mode_special`=0), the vector high byte is read from $FFFE for power-on/pin, from $FFFC for clock-monitor and from $FFFA for watchdog.
- R3: In special mode (`mode_special`=1), the same three causes read from $BFFE, $BFFC and $BFFA.
- R4: The first cycle after reset release is spent in hold. The next cycle reads the even vector address (high byte) and the one after reads the odd address (low byte). The following cycle pulses `start_valid` for one cycle with `start_pc` = {high, low}. `cpu_running` is 1 from the cycle after that.
- R5: `ccr_force` (bit 2 S, bit 1 X, bit 0 I) is 3'b111 from reset until `cpu_running` rises, and 3'b000 while running.
- R6: Every reset sets the watchdog-disable bit (configuration bit 2) to 0 in normal mode and to 1 in special mode; `wdog_en` is its inverse.
- R7: In normal mode, only the first write to the configuration register after reset changes the watchdog-disable bit. Later writes leave it unchanged.
- R8: In special mode, the watchdog-disable bit takes the value of every write.
- R9: While the watchdog-disable bit is 1, a watchdog request does not raise `sys_reset` or restart the fetch.
- R10: Configuration bits 7:4 and bit 0 always read 0. Bits 3 and 1 store the written value at every write and reset to 0.
- R11: The memory-map init register (address 2) resets to $00 on every reset and reads back what was written.
- R12: `sys_reset` is high in the same cycle that any effective request (power-on/pin, clock-monitor, or an enabled watchdog) is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on or external pin reset request |
| clkmon_req | input | 1 | Clock-monitor failure request |
| wdog_req | input | 1 | Watchdog timeout request |
| mode_special | input | 1 | 1 = special mode, 0 = normal mode |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select: 0 config, 1 cause, 2 map init |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Register read data (combinational) |
| fetch_rd | output | 1 | Vector read request |
| fetch_addr | output | 16 | Vector byte address |
| fetch_data | input | 8 | Byte returned for `fetch_addr`, same cycle |
| start_valid | output | 1 | One-cycle pulse: start address is present |
| start_pc | output | 16 | Assembled start address |
| cpu_running | output | 1 | Instruction execution may proceed |
| ccr_force | output | 3 | Forced S, X, I condition-code bits |
| wdog_en | output | 1 | Watchdog enable (inverse of disable bit) |
| sys_reset | output | 1 | System reset in force |
| map_init | output | 8 | Memory-map init register value |

## Verification
The assertions assume that `mode_special` stays at one value from a reset through the end of the following vector fetch. They also assume that the first check happens only after at least one reset has been seen. The bench changes the mode only in the cycle that also raises a reset request. It keeps every request low while the fetch sequence runs, except in the cases where a masked watchdog request is meant to be ignored.

// File: rtl/rv_pkg.sv
package rv_pkg;
  // Reset cause codes; bits double as vector address bits 2:1.
  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_WDOG = 2'd1,
    CAUSE_CMON = 2'd2,
    CAUSE_POR  = 2'd3
  } cause_e;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_HI,
    ST_LO,
    ST_GO,
    ST_RUN
  } seq_e;

  localparam logic [1:0] RA_CFG   = 2'd0;
  localparam logic [1:0] RA_CAUSE = 2'd1;
  localparam logic [1:0] RA_MAP   = 2'd2;
endpackage

// File: rtl/rv_cause.sv
module rv_cause
  import rv_pkg::*;
(
  input  logic   clk,
  input  logic   por_req,
  input  logic   clkmon_req,
  input  logic   wdog_req,
  input  logic   wdog_en,
  input  logic   mode_special,
  output logic   sys_reset,
  output cause_e cause_q,
  output logic   mode_q
);
  cause_e pick;

  assign sys_reset = por_req | clkmon_req | (wdog_req & wdog_en);

  // Fixed priority: pin/power-on over clock monitor over watchdog.
  always_comb begin
    if (por_req)                  pick = CAUSE_POR;
    else if (clkmon_req)          pick = CAUSE_CMON;
    else if (wdog_req && wdog_en) pick = CAUSE_WDOG;
    else                          pick = CAUSE_NONE;
  end

  always_ff @(posedge clk) begin
    if (sys_reset) begin
      cause_q <= pick;
      mode_q  <= mode_special;
    end
  end
endmodule

// File: rtl/rv_seq.sv
module rv_seq
  import rv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] NORM_PAGE = 8'hFF,
  parameter logic [DATA_W-1:0] SPEC_PAGE = 8'hBF
) (
  input  logic              clk,
  input  logic              sys_reset,
  input  cause_e            cause_q,
  input  logic              mode_q,
  input  logic [DATA_W-1:0] fetch_data,
  output logic              fetch_rd,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              start_valid,
  output logic [ADDR_W-1:0] start_pc,
  output logic              cpu_running,
  output logic [2:0]        ccr_force
);
  localparam int LOW_W = ADDR_W - DATA_W;
  localparam int PAD_W = LOW_W - 3;

  seq_e              st_q;
  logic [DATA_W-1:0] hi_q, lo_q;
  logic [LOW_W-1:0]  vec_low;

  // Low part: all ones, then the cause code, then the byte select.
  assign vec_low    = {{PAD_W{1'b1}}, cause_q, (st_q == ST_LO)};
  assign fetch_rd   = (st_q == ST_HI) || (st_q == ST_LO);
  assign fetch_addr = {(mode_q ? SPEC_PAGE : NORM_PAGE), vec_low};

  assign start_valid = (st_q == ST_GO);
  assign start_pc    = {hi_q, lo_q};
  assign cpu_running = (st_q == ST_RUN);
  assign ccr_force   = cpu_running ? 3'b000 : 3'b111;

  always_ff @(posedge clk) begin
    if (sys_reset) begin
      st_q <= ST_HOLD;
    end else begin
      unique case (st_q)
        ST_HOLD: st_q <= ST_HI;
        ST_HI: begin
          hi_q <= fetch_data;
          st_q <= ST_LO;
        end
        ST_LO: begin
          lo_q <= fetch_data;
          st_q <= ST_GO;
        end
        ST_GO:   st_q <= ST_RUN;
        default: st_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/rv_cfg.sv
module rv_cfg
  import rv_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int NOCOP_BIT = 2,
  parameter logic [DATA_W-1:0] CFG_IMPL = 8'h0E
) (
  input  logic              clk,
  input  logic              sys_reset,
  input  logic              mode_special,
  input  logic              mode_q,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  cause_e            cause_q,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wdog_en,
  output logic [DATA_W-1:0] map_init
);
  localparam logic [DATA_W-1:0] NOCOP_MASK = DATA_W'(1) << NOCOP_BIT;
  localparam logic [DATA_W-1:0] OPT_MASK   = CFG_IMPL & ~NOCOP_MASK;

  logic [DATA_W-1:0] opt_q;
  logic              nocop_q;
  logic              locked_q;
  logic [DATA_W-1:0] cfg_view;

  assign wdog_en  = ~nocop_q;
  assign cfg_view = opt_q | (nocop_q ? NOCOP_MASK : '0);

  always_ff @(posedge clk) begin
    if (sys_reset) begin
      opt_q    <= '0;
      nocop_q  <= mode_special;
      locked_q <= 1'b0;
      map_init <= '0;
    end else if (bus_wr) begin
      if (bus_addr == RA_CFG) begin
        opt_q <= bus_wdata & OPT_MASK;
        // Normal mode: first write sticks; special mode: always writable.
        if (mode_q || !locked_q) nocop_q <= bus_wdata[NOCOP_BIT];
        locked_q <= 1'b1;
      end
      if (bus_addr == RA_MAP) map_init <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      RA_CFG:   bus_rdata = cfg_view;
      RA_CAUSE: bus_rdata = DATA_W'(cause_q);
      RA_MAP:   bus_rdata = map_init;
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rstvec_unit.sv
module rstvec_unit
  import rv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] NORM_PAGE = 8'hFF,
  parameter logic [DATA_W-1:0] SPEC_PAGE = 8'hBF
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              clkmon_req,
  input  logic              wdog_req,
  input  logic              mode_special,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              fetch_rd,
  output logic [ADDR_W-1:0] fetch_addr,
  input  logic [DATA_W-1:0] fetch_data,
  output logic              start_valid,
  output logic [ADDR_W-1:0] start_pc,
  output logic              cpu_running,
  output logic [2:0]        ccr_force,
  output logic              wdog_en,
  output logic              sys_reset,
  output logic [DATA_W-1:0] map_init
);
  cause_e cause_q;
  logic   mode_q;

  rv_cause u_cause (
    .clk(clk), .por_req(por_req), .clkmon_req(clkmon_req), .wdog_req(wdog_req),
    .wdog_en(wdog_en), .mode_special(mode_special),
    .sys_reset(sys_reset), .cause_q(cause_q), .mode_q(mode_q)
  );

  rv_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NORM_PAGE(NORM_PAGE), .SPEC_PAGE(SPEC_PAGE)
  ) u_seq (
    .clk(clk), .sys_reset(sys_reset), .cause_q(cause_q), .mode_q(mode_q),
    .fetch_data(fetch_data), .fetch_rd(fetch_rd), .fetch_addr(fetch_addr),
    .start_valid(start_valid), .start_pc(start_pc), .cpu_running(cpu_running),
    .ccr_force(ccr_force)
  );

  rv_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .sys_reset(sys_reset), .mode_special(mode_special), .mode_q(mode_q),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cause_q(cause_q),
    .bus_rdata(bus_rdata), .wdog_en(wdog_en), .map_init(map_init)
  );
endmodule

// File: rtl/rv_chk.sv
module rv_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] NORM_PAGE = 8'hFF,
  parameter logic [DATA_W-1:0] SPEC_PAGE = 8'hBF
) (
  input logic              clk,
  input logic              por_req,
  input logic              clkmon_req,
  input logic              wdog_req,
  input logic              mode_special,
  input logic              bus_wr,
  input logic [1:0]        bus_addr,
  input logic              fetch_rd,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              start_valid,
  input logic              cpu_running,
  input logic [2:0]        ccr_force,
  input logic              wdog_en,
  input logic              sys_reset
);
  logic armed = 1'b0;
  logic cfg_wrote = 1'b0;

  always_ff @(posedge clk) begin
    armed <= armed | sys_reset;
    if (sys_reset) cfg_wrote <= 1'b0;
    else if (bus_wr && bus_addr == 2'd0) cfg_wrote <= 1'b1;
  end

  // R2 R3
  vec_page_chk: assert property (@(posedge clk) disable iff (!armed || sys_reset)
    $fell(sys_reset) |=> fetch_rd && !fetch_addr[0] &&
      fetch_addr[ADDR_W-1:ADDR_W-DATA_W] == (mode_special ? SPEC_PAGE : NORM_PAGE));

  // R4
  hi_then_lo_chk: assert property (@(posedge clk) disable iff (!armed || sys_reset)
    (fetch_rd && !fetch_addr[0]) |=> (fetch_rd && fetch_addr[0]));

  // R4
  lo_then_start_chk: assert property (@(posedge clk) disable iff (!armed || sys_reset)
    (fetch_rd && fetch_addr[0]) |=> (start_valid && !fetch_rd));

  // R4
  start_pulse_chk: assert property (@(posedge clk) disable iff (!armed || sys_reset)
    start_valid |=> (cpu_running && !start_valid));

  // R5
  ccr_mask_chk: assert property (@(posedge clk) disable iff (!armed)
    !cpu_running |-> ccr_force == 3'b111);

  // R7
  write_once_chk: assert property (@(posedge clk) disable iff (!armed || sys_reset)
    (cfg_wrote && !mode_special) |=> $stable(wdog_en));

  // R9
  masked_wdog_chk: assert property (@(posedge clk) disable iff (!armed)
    (wdog_req && !wdog_en && !por_req && !clkmon_req) |-> !sys_reset);

  // R12
  req_reset_chk: assert property (@(posedge clk)
    (por_req || clkmon_req) |-> sys_reset);
endmodule

bind rstvec_unit rv_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NORM_PAGE(NORM_PAGE), .SPEC_PAGE(SPEC_PAGE)
) u_chk (
  .clk(clk), .por_req(por_req), .clkmon_req(clkmon_req), .wdog_req(wdog_req),
  .mode_special(mode_special), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .fetch_rd(fetch_rd), .fetch_addr(fetch_addr), .start_valid(start_valid),
  .cpu_running(cpu_running), .ccr_force(ccr_force), .wdog_en(wdog_en),
  .sys_reset(sys_reset)
);

// File: tb/tb_rstvec_unit.sv
module tb_rstvec_unit;
  logic        clk = 1'b0;
  logic        por_req = 1'b0, clkmon_req = 1'b0, wdog_req = 1'b0, mode_special = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  bus_rdata, fetch_data, map_init;
  logic        fetch_rd, start_valid, cpu_running, wdog_en, sys_reset;
  logic [15:0] fetch_addr, start_pc;
  logic [2:0]  ccr_force;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction
  assign fetch_data = mem(fetch_addr);

  rstvec_unit dut (
    .clk(clk), .por_req(por_req), .clkmon_req(clkmon_req), .wdog_req(wdog_req),
    .mode_special(mode_special), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fetch_rd(fetch_rd),
    .fetch_addr(fetch_addr), .fetch_data(fetch_data), .start_valid(start_valid),
    .start_pc(start_pc), .cpu_running(cpu_running), .ccr_force(ccr_force),
    .wdog_en(wdog_en), .sys_reset(sys_reset), .map_init(map_init)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // Full reset and fetch sequence with checks at every step.
  task automatic t_reset(input bit p, input bit c, input bit w, input bit sp, input logic [1:0] cause);
    logic [15:0] va;
    logic [7:0]  rd;
    string rv;
    rv = sp ? "R3" : "R2";
    va = {(sp ? 8'hBF : 8'hFF), 5'b11111, cause, 1'b0};
    @(negedge clk);
    por_req = p; clkmon_req = c; wdog_req = w; mode_special = sp;
    #1 chk(sys_reset === 1'b1, "R12 sys_reset", 32'(sys_reset), 1);
    @(negedge clk);
    por_req = 0; clkmon_req = 0; wdog_req = 0;
    #1 chk(sys_reset === 1'b0 && fetch_rd === 1'b0, "R4 hold", 32'(fetch_rd), 0);
    chk(ccr_force === 3'b111, "R5 ccr in hold", 32'(ccr_force), 7);
    chk(wdog_en === !sp, "R6 wdog_en reset", 32'(wdog_en), 32'(!sp));
    chk(map_init === 8'h00, "R11 map reset", 32'(map_init), 0);
    read_reg(2'd1, rd);
    chk(rd === {6'd0, cause}, "R1 cause", 32'(rd), 32'(cause));
    read_reg(2'd0, rd);
    chk(rd === (sp ? 8'h04 : 8'h00), "R10 cfg reset", 32'(rd), sp ? 4 : 0);
    @(negedge clk); #1;
    chk(fetch_rd === 1'b1 && fetch_addr === va, {rv, " high addr"}, 32'(fetch_addr), 32'(va));
    @(negedge clk); #1;
    chk(fetch_rd === 1'b1 && fetch_addr === (va | 16'd1), "R4 low addr", 32'(fetch_addr), 32'(va | 16'd1));
    @(negedge clk); #1;
    chk(start_valid === 1'b1 && start_pc === {mem(va), mem(va | 16'd1)}, "R4 start_pc",
        32'(start_pc), 32'({mem(va), mem(va | 16'd1)}));
    chk(ccr_force === 3'b111 && cpu_running === 1'b0, "R5 ccr at start", 32'(ccr_force), 7);
    @(negedge clk); #1;
    chk(cpu_running === 1'b1 && start_valid === 1'b0, "R4 running", 32'(cpu_running), 1);
    chk(ccr_force === 3'b000, "R5 ccr running", 32'(ccr_force), 0);
  endtask

  task automatic t_wdog_masked(input string tag);
    @(negedge clk);
    wdog_req = 1'b1;
    #1 chk(sys_reset === 1'b0, {"R9 no reset ", tag}, 32'(sys_reset), 0);
    @(negedge clk);
    wdog_req = 1'b0;
    #1 chk(cpu_running === 1'b1 && fetch_rd === 1'b0, {"R9 still running ", tag}, 32'(cpu_running), 1);
  endtask

  task automatic t_write_once;
    logic [7:0] rd;
    t_reset(1, 0, 0, 0, 2'd3);
    write_reg(2'd0, 8'hFF);
    read_reg(2'd0, rd);
    chk(rd === 8'h0E, "R10 unimplemented bits zero", 32'(rd), 32'h0E);
    chk(wdog_en === 1'b0, "R7 first write", 32'(wdog_en), 0);
    write_reg(2'd0, 8'h00);
    read_reg(2'd0, rd);
    chk(rd === 8'h04, "R7 second write ignored for bit 2", 32'(rd), 32'h04);
    chk(wdog_en === 1'b0, "R7 wdog stays off", 32'(wdog_en), 0);
    t_wdog_masked("normal");
  endtask

  task automatic t_special_rewrite;
    logic [7:0] rd;
    t_reset(1, 1, 1, 1, 2'd3);
    t_wdog_masked("special");
    write_reg(2'd0, 8'h00);
    chk(wdog_en === 1'b1, "R8 enable", 32'(wdog_en), 1);
    write_reg(2'd0, 8'h04);
    chk(wdog_en === 1'b0, "R8 disable", 32'(wdog_en), 0);
    write_reg(2'd0, 8'h0A);
    read_reg(2'd0, rd);
    chk(wdog_en === 1'b1 && rd === 8'h0A, "R8 R10 rewrite", 32'(rd), 32'h0A);
    t_reset(0, 0, 1, 1, 2'd1);
  endtask

  task automatic t_map;
    logic [7:0] rd;
    write_reg(2'd2, 8'h5A);
    read_reg(2'd2, rd);
    chk(rd === 8'h5A && map_init === 8'h5A, "R11 map write", 32'(rd), 32'h5A);
    write_reg(2'd1, 8'hFF);
    read_reg(2'd1, rd);
    chk(rd === 8'h01, "R1 cause held", 32'(rd), 1);
    t_reset(0, 1, 0, 0, 2'd2);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog timeout", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset(1, 0, 0, 0, 2'd3);
    t_reset(0, 1, 1, 0, 2'd2);
    t_reset(0, 0, 1, 0, 2'd1);
    t_reset(0, 1, 0, 1, 2'd2);
    t_write_once;
    t_special_rewrite;
    t_map;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule